// File: doc/BRIEF.md
# Command-Driven Real-Time Clock with Byte Scratch RAM

This block keeps time as a 32-bit seconds count plus a sub-second fraction. Both advance on a slow tick enable that stands in for a 32.768 kHz clock already brought into the fast domain. The host never reads or writes the counters directly. It reaches them through a shared byte RAM. A host stages a six-byte record through an address register and an auto-incrementing data register. It then writes a transfer code into the control register. The transfer runs on the next slow tick and copies the record between the RAM and either the time counters or the alarm register. Busy reads 1 in the meantime.

The alarm compares against the seconds count. When it matches, it raises a sticky done flag and a level interrupt. Every accepted control write clears the flag, so a no-op write serves as the acknowledgement. Outside transfers the RAM is free scratch storage. A trim register holds a drift-compensation byte that does not change the count.

Top module: `cmd_rtc`

## Requirements
- R1: After reset the control, address and trim registers read 0, the time counters are 0 and `alarm_irq` is low.
- R2: Register index 0 is control: bits [2:0] hold the last accepted code, bit 5 is busy, bit 6 is alarm-done and bit 7 is alarm enable. Every accepted control write loads bit 7 and the code from the written value and sets busy.
- R3: Busy stays set until the first `slow_tick` after the accepting cycle. The transfer executes on that tick and busy clears with it.
- R4: Each `slow_tick` that carries no set-time transfer adds 1 to the FRAC_W-bit fraction. When the fraction wraps from all ones, the seconds count also adds 1, modulo 2^32.
- R5: Code 2 (set time) loads the fraction from the low FRAC_W bits of RAM bytes 0 (low) and 1 (high), and the seconds from bytes 2..5 with the least significant byte at 2.
- R6: Code 1 (get time) writes the fraction and seconds held just before the executing tick into RAM bytes 0..5 in one step, using the R5 layout.
- R7: Code 4 (set alarm) loads the alarm seconds from RAM bytes 2..5. Code 3 (get alarm) writes them back to bytes 2..5 and writes zeros to bytes 0 and 1.
- R8: Register index 1 sets and reads back the RAM pointer. Each access to register index 2 reads or writes the byte at the pointer in bits [7:0], then advances the pointer modulo the RAM depth.
- R9: While busy, data writes are dropped, data reads return the RAM byte without advancing the pointer, and control writes are ignored entirely.
- R10: A tick that moves the seconds count onto the alarm seconds while alarm enable is set raises alarm-done and `alarm_irq`. Both stay high until the next accepted control write. With enable clear, no alarm is raised.
- R11: Register index 3 stores and returns bits [7:0] of the written value and has no effect on timekeeping.
- R12: Codes 0, 5, 6 and 7 run a busy period but move no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slow_tick | input | 1 | One-cycle enable per 32.768 kHz period |
| reg_en | input | 1 | Register access strobe, one access per cycle |
| reg_we | input | 1 | 1 write, 0 read |
| reg_idx | input | 2 | Register index: 0 control, 1 address, 2 data, 3 trim |
| reg_wdata | input | 32 | Write value |
| reg_rdata | output | 32 | Read value for the addressed register, combinational |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
The assertions assume `slow_tick` comes as isolated one-cycle pulses and that at most one register access happens per cycle. They also assume the host stages records only while busy is clear. The stimulus keeps to this by issuing every access and every tick in its own cycle with an idle cycle between them. It also builds a small configuration, a 4-bit fraction and a 16-byte RAM, so that seconds carries, pointer wrap and alarm crossings all occur within short runs.

// File: rtl/cmd_rtc_pkg.sv
package cmd_rtc_pkg;
  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_GET_TIME = 3'd1,
    CMD_SET_TIME = 3'd2,
    CMD_GET_ALM  = 3'd3,
    CMD_SET_ALM  = 3'd4
  } rtc_cmd_e;

  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_ADDR = 2'd1;
  localparam logic [1:0] IDX_DATA = 2'd2;
  localparam logic [1:0] IDX_TRIM = 2'd3;

  localparam int REC_BYTES = 6;
  localparam int REC_W     = REC_BYTES * 8;
  localparam int SEC_W     = 32;
  localparam int EN_BIT    = 7;
endpackage

// File: rtl/rtc_byte_ram.sv
module rtc_byte_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int RW    = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          rec_we,
  input  logic [RW-1:0] rec_wdata,
  output logic [RW-1:0] rec_rdata
);
  localparam int NB = RW / 8;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (host_we) mem[host_addr] <= host_wdata;
    if (rec_we) begin
      for (int b = 0; b < NB; b++) mem[b] <= rec_wdata[8*b +: 8];
    end
  end

  assign host_rdata = mem[host_addr];

  for (genvar g = 0; g < NB; g++) begin : g_rec_rd
    assign rec_rdata[8*g +: 8] = mem[g];
  end

  // R9: a host byte write never lands in the cycle a record transfer writes
  p_no_port_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_we && rec_we));
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int FRAC_W = 16,
  parameter int SW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [FRAC_W-1:0] load_frac,
  input  logic [SW-1:0]     load_sec,
  output logic [FRAC_W-1:0] frac_q,
  output logic [SW-1:0]     sec_q,
  output logic              sec_adv,
  output logic [SW-1:0]     sec_nxt
);
  localparam logic [FRAC_W-1:0] FRAC_ONE = FRAC_W'(1);
  localparam logic [SW-1:0]     SEC_ONE  = SW'(1);

  logic [FRAC_W-1:0] frac_d;
  logic [SW-1:0]     sec_d;

  assign sec_nxt = sec_q + SEC_ONE;

  always_comb begin
    frac_d  = frac_q;
    sec_d   = sec_q;
    sec_adv = 1'b0;
    if (tick) begin
      if (load) begin
        frac_d = load_frac;
        sec_d  = load_sec;
      end else begin
        frac_d = frac_q + FRAC_ONE;
        if (frac_q == '1) begin
          sec_d   = sec_nxt;
          sec_adv = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q <= '0;
      sec_q  <= '0;
    end else if (tick) begin
      frac_q <= frac_d;
      sec_q  <= sec_d;
    end
  end

  p_frac_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (frac_q == FRAC_W'($past(frac_q) + FRAC_ONE)));
  p_sec_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && (frac_q == '1)) |=> (sec_q == SW'($past(sec_q) + SEC_ONE)));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(frac_q) && $stable(sec_q)));
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && load) |=> (sec_q == $past(load_sec)));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] load_sec,
  input  logic          enable,
  input  logic          sec_adv,
  input  logic [SW-1:0] sec_nxt,
  input  logic          clr,
  output logic [SW-1:0] alm_sec_q,
  output logic          done_q
);
  logic fire;
  logic done_d;

  assign fire = sec_adv && enable && (sec_nxt == alm_sec_q);

  always_comb begin
    done_d = done_q;
    if (clr)  done_d = 1'b0;
    if (fire) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alm_sec_q <= '0;
    else if (load) alm_sec_q <= load_sec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr) |=> done_q);
  p_done_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !sec_adv) |=> !done_q);
  p_no_fire_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && !enable) |=> !done_q);
endmodule

// File: rtl/cmd_rtc.sv
module cmd_rtc
  import cmd_rtc_pkg::*;
#(
  parameter int FRAC_W    = 16,
  parameter int RAM_DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        reg_en,
  input  logic        reg_we,
  input  logic [1:0]  reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        alarm_irq
);
  localparam int AW = $clog2(RAM_DEPTH);
  localparam logic [AW-1:0] PTR_ONE = AW'(1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  logic          busy_q, busy_d;
  logic [2:0]    cmd_q, cmd_d;
  logic          en_q, en_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [7:0]    trim_q, trim_d;

  logic ctrl_wr, cmd_accept, addr_wr, trim_wr, data_acc, data_wr_ok, data_rd_ok, exec;

  assign ctrl_wr    = reg_en && reg_we && (reg_idx == IDX_CTRL);
  assign cmd_accept = ctrl_wr && !busy_q;
  assign addr_wr    = reg_en && reg_we && (reg_idx == IDX_ADDR);
  assign trim_wr    = reg_en && reg_we && (reg_idx == IDX_TRIM);
  assign data_acc   = reg_en && (reg_idx == IDX_DATA);
  assign data_wr_ok = data_acc && reg_we && !busy_q;
  assign data_rd_ok = data_acc && !reg_we && !busy_q;
  assign exec       = busy_q && slow_tick;

  logic do_get_time, do_set_time, do_get_alm, do_set_alm;
  assign do_get_time = exec && (cmd_q == CMD_GET_TIME);
  assign do_set_time = exec && (cmd_q == CMD_SET_TIME);
  assign do_get_alm  = exec && (cmd_q == CMD_GET_ALM);
  assign do_set_alm  = exec && (cmd_q == CMD_SET_ALM);

  // next state
  always_comb begin
    busy_d = busy_q;
    cmd_d  = cmd_q;
    en_d   = en_q;
    ptr_d  = ptr_q;
    trim_d = trim_q;
    if (cmd_accept) begin
      busy_d = 1'b1;
      cmd_d  = reg_wdata[2:0];
      en_d   = reg_wdata[EN_BIT];
    end else if (exec) begin
      busy_d = 1'b0;
    end
    if (addr_wr) ptr_d = reg_wdata[AW-1:0];
    else if (data_wr_ok || data_rd_ok) ptr_d = ptr_q + PTR_ONE;
    if (trim_wr) trim_d = reg_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      busy_q <= 1'b0;
      cmd_q  <= 3'd0;
      en_q   <= 1'b0;
      ptr_q  <= '0;
      trim_q <= 8'd0;
    end else begin
      busy_q <= busy_d;
      cmd_q  <= cmd_d;
      en_q   <= en_d;
      ptr_q  <= ptr_d;
      trim_q <= trim_d;
    end
  end

  // datapath
  logic [FRAC_W-1:0] frac_q;
  logic [SEC_W-1:0]  sec_q, sec_nxt, alm_sec_q;
  logic              sec_adv, done_q;
  logic [7:0]        host_rdata;
  logic [REC_W-1:0]  rec_rdata, rec_wdata;
  logic [15:0]       frac16;

  assign frac16    = 16'(frac_q);
  assign rec_wdata = do_get_time ? {sec_q, frac16} : {alm_sec_q, 16'h0000};

  rtc_byte_ram #(.DEPTH(RAM_DEPTH), .AW(AW), .RW(REC_W)) u_ram (
    .clk        (clk),
    .rst_n      (rst_int),
    .host_we    (data_wr_ok),
    .host_addr  (ptr_q),
    .host_wdata (reg_wdata[7:0]),
    .host_rdata (host_rdata),
    .rec_we     (do_get_time || do_get_alm),
    .rec_wdata  (rec_wdata),
    .rec_rdata  (rec_rdata)
  );

  rtc_timebase #(.FRAC_W(FRAC_W), .SW(SEC_W)) u_time (
    .clk       (clk),
    .rst_n     (rst_int),
    .tick      (slow_tick),
    .load      (do_set_time),
    .load_frac (rec_rdata[FRAC_W-1:0]),
    .load_sec  (rec_rdata[REC_W-1:16]),
    .frac_q    (frac_q),
    .sec_q     (sec_q),
    .sec_adv   (sec_adv),
    .sec_nxt   (sec_nxt)
  );

  rtc_alarm #(.SW(SEC_W)) u_alarm (
    .clk       (clk),
    .rst_n     (rst_int),
    .load      (do_set_alm),
    .load_sec  (rec_rdata[REC_W-1:16]),
    .enable    (en_q),
    .sec_adv   (sec_adv),
    .sec_nxt   (sec_nxt),
    .clr       (cmd_accept),
    .alm_sec_q (alm_sec_q),
    .done_q    (done_q)
  );

  if (FRAC_W < 16) begin : g_frac_pad
    logic unused_frac_hi;
    assign unused_frac_hi = ^rec_rdata[15:FRAC_W];
  end
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^reg_wdata[31:8];

  // read mux
  always_comb begin
    unique case (reg_idx)
      IDX_CTRL: reg_rdata = {24'd0, en_q, done_q, busy_q, 2'b00, cmd_q};
      IDX_ADDR: reg_rdata = 32'(ptr_q);
      IDX_DATA: reg_rdata = {24'd0, host_rdata};
      default:  reg_rdata = {24'd0, trim_q};
    endcase
  end

  assign alarm_irq = done_q;

  p_busy_clears_r3: assert property (@(posedge clk) disable iff (!rst_int)
    (busy_q && slow_tick) |=> !busy_q);
  p_busy_waits_r3: assert property (@(posedge clk) disable iff (!rst_int)
    (busy_q && !slow_tick) |=> busy_q);
  p_enable_loaded_r2: assert property (@(posedge clk) disable iff (!rst_int)
    cmd_accept |=> (en_q == $past(reg_wdata[EN_BIT])) && busy_q);
  p_ctrl_ignored_r9: assert property (@(posedge clk) disable iff (!rst_int)
    (busy_q && ctrl_wr) |=> ($stable(en_q) && $stable(cmd_q)));
  p_ptr_frozen_r9: assert property (@(posedge clk) disable iff (!rst_int)
    (busy_q && data_acc) |=> $stable(ptr_q));
endmodule

// File: tb/test_cmd_rtc.sv
module test_cmd_rtc;
  localparam int FW    = 4;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        reg_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_idx = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        alarm_irq;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [FW-1:0] m_frac;
  logic [31:0]   m_sec;

  always #5 clk = ~clk;

  cmd_rtc #(.FRAC_W(FW), .RAM_DEPTH(DEPTH)) i_cmd_rtc (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .reg_en(reg_en),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alarm_irq(alarm_irq)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_idx = idx;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_en = 1'b0;
  endtask

  // one slow tick; model advances as plain counting
  task automatic pulse();
    @(negedge clk);
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
    m_frac = m_frac + 1'b1;
    if (m_frac == '0) m_sec = m_sec + 1;
  endtask

  task automatic stage(input logic [47:0] rec);
    wr(2'd1, 32'd0);
    for (int b = 0; b < 6; b++) wr(2'd2, {24'd0, rec[8*b +: 8]});
  endtask

  task automatic read6(output logic [47:0] rec);
    logic [31:0] d;
    wr(2'd1, 32'd0);
    for (int b = 0; b < 6; b++) begin
      rd(2'd2, d);
      rec[8*b +: 8] = d[7:0];
    end
  endtask

  task automatic get_time_check(input string tag);
    logic [47:0] rec;
    logic [47:0] exp;
    exp = {m_sec, 12'd0, m_frac};
    wr(2'd0, 32'h0000_0001 | {24'd0, i_en_cache, 7'd0});
    pulse();
    read6(rec);
    chk(64'(rec), 64'(exp), tag);
  endtask

  logic i_en_cache = 1'b0;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic [47:0] rec;
    logic [7:0]  pat [DEPTH];
    m_frac = '0;
    m_sec  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk(64'(d), 64'h0, "R1 control");
    rd(2'd1, d); chk(64'(d), 64'h0, "R1 address");
    rd(2'd3, d); chk(64'(d), 64'h0, "R1 trim");
    chk(64'(alarm_irq), 64'h0, "R1 irq");

    // R8 full RAM sweep with pointer wrap
    wr(2'd1, 32'd0);
    for (int i = 0; i < DEPTH; i++) begin
      pat[i] = 8'((i * 37 + 5) & 255);
      wr(2'd2, {24'd0, pat[i]});
    end
    rd(2'd1, d); chk(64'(d), 64'h0, "R8 pointer wrap after writes");
    for (int i = 0; i < DEPTH; i++) begin
      rd(2'd2, d); chk(64'(d), 64'(pat[i]), "R8 sequential read");
    end
    wr(2'd1, 32'(DEPTH - 2));
    for (int i = 0; i < 3; i++) begin
      rd(2'd2, d); chk(64'(d), 64'(pat[(DEPTH - 2 + i) % DEPTH]), "R8 read across wrap");
    end
    rd(2'd1, d); chk(64'(d), 64'h1, "R8 pointer readback");

    // R11 trim storage
    wr(2'd3, 32'h0000_01A5);
    rd(2'd3, d); chk(64'(d), 64'hA5, "R11 trim readback");

    // R5 R2 R3 set time
    stage({32'h1234_5678, 16'h0003});
    wr(2'd0, 32'h0000_0002);
    rd(2'd0, d); chk(64'(d), 64'h22, "R2 busy and code after write");
    repeat (3) @(negedge clk);
    rd(2'd0, d); chk(64'(d), 64'h22, "R3 busy held without tick");
    pulse();
    m_frac = 4'd3; m_sec = 32'h1234_5678;
    rd(2'd0, d); chk(64'(d), 64'h02, "R3 busy cleared by tick");

    // R6 get time captures pre-tick value
    get_time_check("R6 get time after set");

    // R4 counting sweep
    for (int k = 0; k < 4; k++) begin
      int n;
      n = (k == 0) ? 1 : (k == 1) ? 11 : (k == 2) ? 12 : 40;
      for (int t = 0; t < n; t++) pulse();
      get_time_check("R4 count after ticks");
    end

    // R4 seconds wrap modulo 2^32
    stage({32'hFFFF_FFFF, 16'h000E});
    wr(2'd0, 32'h0000_0002);
    pulse();
    m_frac = 4'hE; m_sec = 32'hFFFF_FFFF;
    pulse(); pulse();
    get_time_check("R4 seconds wrap");

    // R9 accesses while busy
    wr(2'd1, 32'd8);
    wr(2'd0, 32'h0000_0000);
    wr(2'd2, 32'h0000_00EE);
    rd(2'd1, d); chk(64'(d), 64'h8, "R9 pointer not advanced by write");
    rd(2'd2, d); chk(64'(d), 64'(pat[8]), "R9 read while busy");
    rd(2'd2, d); chk(64'(d), 64'(pat[8]), "R9 second read same byte");
    wr(2'd0, 32'h0000_0084);
    rd(2'd0, d); chk(64'(d), 64'h20, "R9 control write ignored");
    pulse();
    rd(2'd0, d); chk(64'(d), 64'h00, "R9 enable still clear");
    wr(2'd1, 32'd8);
    rd(2'd2, d); chk(64'(d), 64'(pat[8]), "R9 dropped write");

    // R7 set alarm then get alarm
    stage({32'hCAFE_F00D, 16'h6655});
    wr(2'd0, 32'h0000_0084);
    i_en_cache = 1'b1;
    pulse();
    rd(2'd0, d); chk(64'(d), 64'h84, "R7 set alarm with enable");
    stage(48'hFFFF_FFFF_FFFF);
    wr(2'd0, 32'h0000_0083);
    pulse();
    read6(rec); chk(64'(rec), 64'hCAFE_F00D_0000, "R7 get alarm record");

    // R10 alarm fires on seconds crossing
    stage({32'd1000, 16'h0000});
    wr(2'd0, 32'h0000_0082);
    pulse();
    m_frac = '0; m_sec = 32'd1000;
    stage({32'd1001, 16'h0000});
    wr(2'd0, 32'h0000_0084);
    pulse();
    while (m_frac != '1) begin
      pulse();
      chk(64'(alarm_irq), 64'h0, "R10 no irq before crossing");
    end
    pulse();
    chk(64'(alarm_irq), 64'h1, "R10 irq at crossing");
    rd(2'd0, d); chk(64'(d), 64'hC4, "R10 done flag set");
    pulse(); pulse();
    chk(64'(alarm_irq), 64'h1, "R10 irq held");
    wr(2'd0, 32'h0000_0080);
    chk(64'(alarm_irq), 64'h0, "R10 acknowledge clears irq");
    rd(2'd0, d); chk(64'(d), 64'hA0, "R10 done cleared busy set");
    pulse();

    // R10 disabled alarm stays quiet
    stage({m_sec + 32'd1, 16'h0000});
    wr(2'd0, 32'h0000_0004);
    i_en_cache = 1'b0;
    pulse();
    for (int t = 0; t < 18; t++) pulse();
    chk(64'(alarm_irq), 64'h0, "R10 no irq when disabled");
    rd(2'd0, d); chk(64'(d), 64'h04, "R10 done stays clear");

    // R12 unused code moves nothing; R11 trim left time untouched
    stage(48'h0102_0304_0506);
    wr(2'd0, 32'h0000_0005);
    rd(2'd0, d); chk(64'(d), 64'h25, "R12 code 5 busy");
    pulse();
    rd(2'd0, d); chk(64'(d), 64'h05, "R12 code 5 done");
    read6(rec); chk(64'(rec), 64'h0102_0304_0506, "R12 RAM unchanged");
    get_time_check("R11 R12 time keeps counting");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule